// File: doc/BRIEF.md
# Double-Buffered Nibble-Addressed DAC Code Register

This block is the digital front end of a parallel-input digital-to-analog converter. A host writes a 12-bit word through an 8-bit data port as 4-bit nibbles. The host uses two address lines and active-low select and write strobes. The word goes into an input latch. An active-low load then copies the input latch into a second, DAC-side latch. The upper 10 bits of that latch are the conversion code. The two lowest bits are sub-LSBs and must always be written as zero. A sticky flag reports any write that broke this rule.

The host pins are asynchronous to the system clock. Select, write, load, address and data pass through the same synchronizer chain, so they keep their relative timing. A write takes effect on the sampled rising edge of the write strobe. While the load is held low, the DAC latch follows the input latch on every clock, including a write made in that same clock. The DAC latch therefore behaves as transparent, and it keeps the last value once the load is released. An active-low clear and the power-on reset act without waiting for the clock. A 4-bit host drives the same nibble on both halves of the data port.

Top module: `nibble_dac_reg`

## Requirements
- R1: While `rst_n` is low, `code` reads 0 and `sub_err` reads 0. The DAC latch and the input latch both start at zero.
- R2: A write with address `addr` = 2'b11 loads `din[3:0]` into the high nibble (word bits [11:8], `code[9:6]`). The other nibbles keep their values.
- R3: A write with `addr` = 2'b10 loads `din[3:0]` into the low nibble only (word bits [3:0]). Word bits [1:0] are the sub-LSBs and word bits [3:2] appear as `code[1:0]`.
- R4: A write with `addr` = 2'b01 loads `din[7:4]` into the middle nibble only (word bits [7:4], `code[5:2]`). `din[3:0]` is ignored.
- R5: A write with `addr` = 2'b00 loads `din[3:0]` into the low nibble and `din[7:4]` into the middle nibble in one access.
- R6: A write strobe with `cs_n` high changes no nibble. Holding `cs_n` low without a write-strobe pulse also changes no nibble.
- R7: While the load is high, `code` holds its value whatever the writes do. A low pulse on `ld_n` copies the input latch to the DAC latch within 6 clock cycles, and the value is kept after `ld_n` rises.
- R8: While `ld_n` is held low, each completed write appears at `code` without a further load pulse. A write to the high nibble therefore reaches the DAC latch in the same clock as the input latch.
- R9: A low `clr_n` forces `code` to 0 at once, without a clock edge and regardless of `cs_n`. While `clr_n` is low, `code` stays 0 even with `ld_n` low. The input latch keeps its contents through a clear.
- R10: `sub_err` is set by any write that loads the low nibble (address 2'b10 or 2'b00) with `din[1:0]` nonzero. It stays set across later legal writes and loads. `clr_n` low or `rst_n` low clears it.
- R11: `code` always equals bits [11:2] of the DAC latch. It is the value loaded as {high, middle, low} nibbles with the two sub-LSBs dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low, takes effect on its rising edge |
| ld_n | input | 1 | Load to DAC latch, active low, transparent while low |
| clr_n | input | 1 | Clear of the DAC latch and error flag, active low, asynchronous |
| addr | input | 2 | Nibble select: 11 high, 10 low, 01 middle, 00 low and middle |
| din | input | 8 | Data port; [3:0] low or high nibble, [7:4] middle nibble |
| code | output | 10 | Conversion code, DAC latch bits [11:2] |
| sub_err | output | 1 | Sticky flag for a nonzero sub-LSB write |

## Verification
The bench runs each address mode against a latch that already holds other data. This catches a decoder that writes a neighbouring nibble or takes the middle nibble from the wrong half of the port. It writes with the load high and then with the load held low. A design that copied only on the load edge would miss the transparent update, and one that copied without a load would show new codes early. The clear is applied with the load low and then released. A design that wiped the input latch, or let the load beat the clear, would show a wrong code. A bad sub-LSB write followed by legal traffic exposes a flag that is not sticky or that clear does not reset.

// File: rtl/nibble_dac_reg.sv
module nibble_dac_reg #(
  parameter int SYNC_STAGES = 2,
  parameter int NIB_W       = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 wr_n,
  input  logic                 ld_n,
  input  logic                 clr_n,
  input  logic [1:0]           addr,
  input  logic [2*NIB_W-1:0]   din,
  output logic [3*NIB_W-3:0]   code,
  output logic                 sub_err
);
  localparam int DW   = 2 * NIB_W;
  localparam int LW   = 3 * NIB_W;
  localparam int SW   = DW + 5;
  localparam int P_LD = DW + 2;
  localparam int P_WR = DW + 3;
  localparam int P_CS = DW + 4;
  localparam logic [SW-1:0] IDLE = {3'b111, {(SW-3){1'b0}}};

  logic [SW-1:0] pipe [SYNC_STAGES+1];
  logic [SW-1:0] sy, dl;
  logic [LW-1:0] inl, in_nxt, dac;
  logic          wr_fire, lo_en, mid_en, hi_en, ld_act, clr_all_n;
  logic [1:0]    a;
  logic [DW-1:0] d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= SYNC_STAGES; i++) pipe[i] <= IDLE;
    end else begin
      pipe[0] <= {cs_n, wr_n, ld_n, addr, din};
      for (int i = 1; i <= SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign sy      = pipe[SYNC_STAGES-1];
  assign dl      = pipe[SYNC_STAGES];
  assign a       = dl[DW+1:DW];
  assign d       = dl[DW-1:0];
  assign wr_fire = sy[P_WR] & ~dl[P_WR] & ~dl[P_CS];
  assign hi_en   = wr_fire & (a == 2'b11);
  assign lo_en   = wr_fire & ~a[0];
  assign mid_en  = wr_fire & ~a[1];
  assign ld_act  = ~dl[P_LD];

  assign in_nxt[NIB_W-1:0]    = lo_en  ? d[NIB_W-1:0]  : inl[NIB_W-1:0];
  assign in_nxt[DW-1:NIB_W]   = mid_en ? d[DW-1:NIB_W] : inl[DW-1:NIB_W];
  assign in_nxt[LW-1:DW]      = hi_en  ? d[NIB_W-1:0]  : inl[LW-1:DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inl <= '0;
    else        inl <= in_nxt;
  end

  assign clr_all_n = rst_n & clr_n;

  always_ff @(posedge clk or negedge clr_all_n) begin
    if (!clr_all_n) begin
      dac     <= '0;
      sub_err <= 1'b0;
    end else begin
      if (ld_act) dac <= in_nxt;
      if (lo_en && (d[1:0] != 2'b00)) sub_err <= 1'b1;
    end
  end

  assign code = dac[LW-1:2];
endmodule

module nibble_dac_reg_chk #(
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_n,
  input logic          ld_act,
  input logic          wr_fire,
  input logic [CW-1:0] code,
  input logic          sub_err
);
  AST_RST_CLEARS: assert property (@(posedge clk)
    !rst_n |-> (code == '0 && !sub_err)); // R1

  AST_CLR_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (code == '0 && !sub_err)); // R9

  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    !ld_act |=> $stable(code)); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    sub_err |=> sub_err); // R10

  AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    $rose(sub_err) |-> $past(wr_fire)); // R10
endmodule

bind nibble_dac_reg nibble_dac_reg_chk #(.CW(3*NIB_W-2)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ld_act(ld_act),
  .wr_fire(wr_fire), .code(code), .sub_err(sub_err)
);

// File: tb/nibble_dac_reg_test.sv
module nibble_dac_reg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0, cs_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1, clr_n = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [7:0] din = 8'h00;
  logic [9:0] code;
  logic       sub_err;

  int checks = 0, fails = 0;
  logic [10:0] exp_q[$];
  string       req_q[$];
  logic [11:0] m_inl = '0, m_dac = '0;
  logic        m_err = 1'b0;

  always #2 clk = ~clk;

  nibble_dac_reg uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n),
    .clr_n(clr_n), .addr(addr), .din(din), .code(code), .sub_err(sub_err));

  task automatic chk(input string req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual err=%0b code=%h expected err=%0b code=%h",
               req, act[10], act[9:0], exp[10], exp[9:0]);
    end
  endtask

  task automatic expect_now(input string req);
    exp_q.push_back({m_err, m_dac[11:2]});
    req_q.push_back(req);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) chk(req_q.pop_front(), {sub_err, code}, exp_q.pop_front());
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input bit sel);
    @(negedge clk);
    addr = a; din = d; cs_n = !sel; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    if (sel) begin
      if (a == 2'b11) m_inl[11:8] = d[3:0];
      if (!a[0]) begin
        m_inl[3:0] = d[3:0];
        if (d[1:0] != 2'b00 && clr_n) m_err = 1'b1;
      end
      if (!a[1]) m_inl[7:4] = d[7:4];
      if (!ld_n && clr_n) m_dac = m_inl;
    end
  endtask

  task automatic ld_pulse();
    @(negedge clk);
    ld_n = 1'b0;
    repeat (4) @(negedge clk);
    ld_n = 1'b1;
    repeat (6) @(negedge clk);
    if (clr_n) m_dac = m_inl;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", {sub_err, code}, 11'h000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    bus_wr(2'b00, 8'hA4, 1);                    // R5 low+middle
    bus_wr(2'b11, 8'h05, 1);                    // R2 high
    expect_now("R7 no load, code held");
    ld_pulse();
    expect_now("R5 R2 R11 load 0x5A4");

    bus_wr(2'b10, 8'hFC, 1);
    ld_pulse();
    expect_now("R3 low nibble only");

    bus_wr(2'b01, 8'h3F, 1);
    ld_pulse();
    expect_now("R4 middle nibble only");

    bus_wr(2'b11, 8'h0F, 0);
    @(negedge clk); cs_n = 1'b0; addr = 2'b00; din = 8'hFF;
    repeat (8) @(negedge clk); cs_n = 1'b1;
    ld_pulse();
    expect_now("R6 deselected writes ignored");

    @(negedge clk); ld_n = 1'b0;
    repeat (6) @(negedge clk);
    bus_wr(2'b11, 8'h09, 1);
    expect_now("R8 transparent high-nibble write");
    @(negedge clk); ld_n = 1'b1;
    repeat (6) @(negedge clk);
    bus_wr(2'b00, 8'h00, 1);
    expect_now("R7 held after load rises");

    @(negedge clk); clr_n = 1'b0; m_dac = '0; m_err = 1'b0;
    #1 chk("R9 async clear", {sub_err, code}, 11'h000);
    @(negedge clk); ld_n = 1'b0;
    repeat (8) @(negedge clk);
    expect_now("R9 clear beats load");
    ld_n = 1'b1; clr_n = 1'b1;
    repeat (6) @(negedge clk);
    ld_pulse();
    expect_now("R9 input latch kept");

    bus_wr(2'b10, 8'h01, 1);
    expect_now("R10 flag set on bad sub-LSB");
    bus_wr(2'b00, 8'h50, 1);
    ld_pulse();
    expect_now("R10 flag sticky");
    @(negedge clk); clr_n = 1'b0; m_dac = '0; m_err = 1'b0;
    repeat (3) @(negedge clk); clr_n = 1'b1;
    repeat (2) @(negedge clk);
    expect_now("R10 clear resets flag");

    bus_wr(2'b11, 8'h0C, 1);
    ld_pulse();
    expect_now("R11 code from upper bits");
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R1 reset mid-run", {sub_err, code}, 11'h000);
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule